// File: doc/BRIEF.md
# Receive Character Queue with Error Status Reporting

This block sits between a serial receiver's shift register and the host. It stores a small number of received characters. Each character carries its own parity-error, framing-error and break flags, and the host reads them from the oldest entry. When the queue is full, one more character can wait in a holding stage that stands for the receiver's shift register. If further characters arrive while the queue stays full, each one overwrites that held character. A start bit seen in this state raises a sticky overrun flag.

Error status is reported in one of two modes. In per-character mode the status shows the flags of the oldest entry only. In accumulated mode the status collects those flags from every entry that has been oldest since the last error-reset command. The block also drives an active-low request-to-send output for automatic flow control, and an interrupt request chosen from "data present" or "queue full".

Top module: `rx_char_queue`

## Requirements
- R1: The queue holds at most DEPTH (default 3) characters. `q_full` is 1 exactly when DEPTH characters are stored.
- R2: `q_ready` is 1 when at least one character is stored. `top_data` shows the oldest stored character, or zero when the queue is empty.
- R3: A cycle with `rd_en` high on a non-empty queue removes the oldest entry together with its flags. `rd_en` on an empty queue changes no state and no output.
- R4: With `cfg_accum` low, `st_par`, `st_frm` and `st_brk` show the flags of the oldest entry, or zero when the queue is empty.
- R5: With `cfg_accum` high, each status flag is the OR of the oldest entry's flag over every cycle since the last `err_clr`, including the current oldest entry. `err_clr` empties this accumulation.
- R6: A character written while the queue is full and no read occurs is kept in a holding stage. Each later write while the queue stays full replaces the held character. On the first read, the held character enters the queue behind the older entries.
- R7: `overrun` is set in the cycle after `start_seen` is high while the queue is full, a character is held, and `rd_en` is low. It stays set until `err_clr`. A new setting condition wins over a clear in the same cycle.
- R8: `brk_event` is set in the cycle after a write with `in_brk` high. It stays set until `err_clr`, and a new break wins over a clear in the same cycle.
- R9: With `cfg_auto_rts` high, `rts_n` goes to 1 in the cycle after `start_seen` is seen while the queue is full. It returns to 0 in the cycle after the queue is seen below full. With `cfg_auto_rts` low, `rts_n` is 0.
- R10: `irq` equals `q_full` when `cfg_irq_full` is high and `q_ready` otherwise.
- R11: A read and a write in the same cycle on a full queue lose no character. The written character is stored behind the remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A received character is complete |
| in_data | input | 8 | Character data |
| in_par | input | 1 | Parity error flag of the character |
| in_frm | input | 1 | Framing error flag of the character |
| in_brk | input | 1 | Break flag of the character |
| start_seen | input | 1 | Pulse: receiver detected a valid start bit |
| rd_en | input | 1 | Host data read; pops the oldest entry |
| err_clr | input | 1 | Error-reset command |
| cfg_accum | input | 1 | 1 selects accumulated status, 0 per-character status |
| cfg_auto_rts | input | 1 | Enables automatic flow control on rts_n |
| cfg_irq_full | input | 1 | 1: irq follows q_full, 0: irq follows q_ready |
| top_data | output | 8 | Oldest character, zero when empty |
| q_ready | output | 1 | At least one character stored |
| q_full | output | 1 | All positions occupied |
| st_par | output | 1 | Parity error status |
| st_frm | output | 1 | Framing error status |
| st_brk | output | 1 | Received break status |
| overrun | output | 1 | Sticky overrun flag |
| brk_event | output | 1 | Sticky break-seen flag |
| rts_n | output | 1 | Active-low request to send |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is driven to a known value on every clock edge once reset is released. They also assume `start_seen` and `wr_en` are single-cycle strobes whose meaning does not depend on their history, so any combination of them is legal. The bench changes inputs only on the falling clock edge. It produces both directed sequences and random traffic over the whole input space, including reads of an empty queue, writes during overrun and configuration changes in mid-stream. No input stays unknown after reset.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_flags_t;

    function automatic rx_flags_t flags_of(input rx_entry_t e);
        rx_flags_t f;
        f.brk = e.brk;
        f.frm = e.frm;
        f.par = e.par;
        return f;
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_entry_t                  push_entry,
    input  logic                       pop,
    output rx_entry_t                  top,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t         mem [DEPTH];
    logic [PW-1:0]     rd_ptr, wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign top = (count != '0) ? mem[rd_ptr] : '0;

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !push) |=> (count == '0));
endmodule

// File: rtl/rxq_ingress.sv
module rxq_ingress
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  rx_entry_t                  wr_entry,
    input  logic                       pop,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       push,
    output rx_entry_t                  push_entry,
    output logic                       hold_valid
);
    localparam int CW = $clog2(DEPTH+1);

    rx_entry_t hold;
    logic      room;

    assign room = (count < CW'(DEPTH)) || pop;

    always_comb begin
        if (hold_valid) begin
            push       = room;
            push_entry = hold;
        end else begin
            push       = wr_en && room;
            push_entry = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold       <= '0;
        end else begin
            if (wr_en && (hold_valid || !room)) hold <= wr_entry;
            if (hold_valid && room)             hold_valid <= wr_en;
            else if (!hold_valid && wr_en && !room) hold_valid <= 1'b1;
        end
    end

    // R6
    hold_only_full_chk: assert property (@(posedge clk) disable iff (rst)
        hold_valid |-> (count == CW'(DEPTH)));
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  rx_flags_t                  top_flags,
    input  logic                       hold_valid,
    input  logic                       rd_en,
    input  logic                       start_seen,
    input  logic                       wr_en,
    input  logic                       in_brk,
    input  logic                       err_clr,
    input  logic                       cfg_accum,
    input  logic                       cfg_auto_rts,
    input  logic                       cfg_irq_full,
    output rx_flags_t                  status,
    output logic                       q_ready,
    output logic                       q_full,
    output logic                       overrun,
    output logic                       brk_event,
    output logic                       rts_n,
    output logic                       irq
);
    localparam int CW = $clog2(DEPTH+1);

    rx_flags_t acc;
    logic      ovr_set;

    assign q_ready = (count != '0);
    assign q_full  = (count == CW'(DEPTH));
    assign irq     = cfg_irq_full ? q_full : q_ready;
    assign status  = cfg_accum ? (acc | top_flags) : top_flags;
    assign ovr_set = start_seen && q_full && hold_valid && !rd_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            overrun   <= 1'b0;
            brk_event <= 1'b0;
            rts_n     <= 1'b0;
        end else begin
            acc       <= err_clr ? rx_flags_t'('0) : (acc | top_flags);
            overrun   <= (overrun && !err_clr) || ovr_set;
            brk_event <= (brk_event && !err_clr) || (wr_en && in_brk);
            if (!cfg_auto_rts)            rts_n <= 1'b0;
            else if (start_seen && q_full) rts_n <= 1'b1;
            else if (!q_full)             rts_n <= 1'b0;
        end
    end

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !err_clr) |=> overrun);

    // R8
    brk_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_event && !err_clr) |=> brk_event);

    // R9
    rts_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!rts_n && !(start_seen && cfg_auto_rts)) |=> !rts_n);
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_par,
    input  logic              in_frm,
    input  logic              in_brk,
    input  logic              start_seen,
    input  logic              rd_en,
    input  logic              err_clr,
    input  logic              cfg_accum,
    input  logic              cfg_auto_rts,
    input  logic              cfg_irq_full,
    output logic [DATA_W-1:0] top_data,
    output logic              q_ready,
    output logic              q_full,
    output logic              st_par,
    output logic              st_frm,
    output logic              st_brk,
    output logic              overrun,
    output logic              brk_event,
    output logic              rts_n,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH+1);

    rx_entry_t     wr_entry, push_entry, top;
    rx_flags_t     status;
    logic          push, pop, hold_valid;
    logic [CW-1:0] count;

    assign wr_entry = '{brk: in_brk, frm: in_frm, par: in_par, data: in_data};
    assign pop      = rd_en && (count != '0);

    rxq_ingress #(.DEPTH(DEPTH)) u_ingress (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_entry(wr_entry), .pop(pop),
        .count(count), .push(push), .push_entry(push_entry), .hold_valid(hold_valid)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .push_entry(push_entry), .pop(pop),
        .top(top), .count(count)
    );

    rxq_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst(rst), .count(count), .top_flags(flags_of(top)),
        .hold_valid(hold_valid), .rd_en(rd_en), .start_seen(start_seen),
        .wr_en(wr_en), .in_brk(in_brk), .err_clr(err_clr),
        .cfg_accum(cfg_accum), .cfg_auto_rts(cfg_auto_rts), .cfg_irq_full(cfg_irq_full),
        .status(status), .q_ready(q_ready), .q_full(q_full), .overrun(overrun),
        .brk_event(brk_event), .rts_n(rts_n), .irq(irq)
    );

    assign top_data = top.data;
    assign st_par   = status.par;
    assign st_frm   = status.frm;
    assign st_brk   = status.brk;
endmodule

// File: tb/rx_char_queue_bench.sv
module rx_char_queue_bench;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, in_par = 0, in_frm = 0, in_brk = 0, start_seen = 0, rd_en = 0, err_clr = 0;
    logic cfg_accum = 0, cfg_auto_rts = 0, cfg_irq_full = 0;
    logic [7:0] in_data = 0;
    logic [7:0] top_data;
    logic q_ready, q_full, st_par, st_frm, st_brk, overrun, brk_event, rts_n, irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    rx_char_queue u_rx_char_queue (
        .clk(clk), .rst(rst), .wr_en(wr_en), .in_data(in_data), .in_par(in_par),
        .in_frm(in_frm), .in_brk(in_brk), .start_seen(start_seen), .rd_en(rd_en),
        .err_clr(err_clr), .cfg_accum(cfg_accum), .cfg_auto_rts(cfg_auto_rts),
        .cfg_irq_full(cfg_irq_full), .top_data(top_data), .q_ready(q_ready),
        .q_full(q_full), .st_par(st_par), .st_frm(st_frm), .st_brk(st_brk),
        .overrun(overrun), .brk_event(brk_event), .rts_n(rts_n), .irq(irq)
    );

    // reference model state: entries are {brk, frm, par, data}
    logic [10:0] mq[$];
    logic [10:0] m_hold = '0;
    logic        m_hold_v = 0, m_ovr = 0, m_brk = 0, m_rts = 0;
    logic [2:0]  m_acc = '0;

    function automatic logic [2:0] m_top_flags();
        return (mq.size() > 0) ? mq[0][10:8] : 3'b000;
    endfunction

    task automatic model_step();
        logic [10:0] nw;
        logic pop, full_pre;
        if (rst) begin
            mq.delete(); m_hold_v = 0; m_ovr = 0; m_brk = 0; m_rts = 0; m_acc = '0;
            return;
        end
        nw = {in_brk, in_frm, in_par, in_data};
        pop = rd_en && mq.size() > 0;
        full_pre = (mq.size() == D);
        m_acc = err_clr ? 3'b000 : (m_acc | m_top_flags());
        m_ovr = (m_ovr && !err_clr) || (start_seen && full_pre && m_hold_v && !rd_en);
        m_brk = (m_brk && !err_clr) || (wr_en && in_brk);
        if (!cfg_auto_rts) m_rts = 0;
        else if (start_seen && full_pre) m_rts = 1;
        else if (!full_pre) m_rts = 0;
        if (pop) void'(mq.pop_front());
        if (m_hold_v) begin
            if (mq.size() < D) begin
                mq.push_back(m_hold);
                if (wr_en) m_hold = nw; else m_hold_v = 0;
            end else if (wr_en) m_hold = nw;
        end else if (wr_en) begin
            if (mq.size() < D) mq.push_back(nw);
            else begin m_hold = nw; m_hold_v = 1; end
        end
    endtask

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] ed;
        logic [2:0] ef;
        ed = (mq.size() > 0) ? mq[0][7:0] : 8'h00;
        ef = cfg_accum ? (m_acc | m_top_flags()) : m_top_flags();
        chk(top_data == ed, "R2/R3/R6/R11 top_data", top_data, ed);
        chk(q_ready == (mq.size() > 0), "R2 q_ready", {7'd0, q_ready}, {7'd0, mq.size() > 0});
        chk(q_full == (mq.size() == D), "R1 q_full", {7'd0, q_full}, {7'd0, mq.size() == D});
        chk({st_brk, st_frm, st_par} == ef, cfg_accum ? "R5 status" : "R4 status",
            {5'd0, st_brk, st_frm, st_par}, {5'd0, ef});
        chk(overrun == m_ovr, "R7 overrun", {7'd0, overrun}, {7'd0, m_ovr});
        chk(brk_event == m_brk, "R8 brk_event", {7'd0, brk_event}, {7'd0, m_brk});
        chk(rts_n == m_rts, "R9 rts_n", {7'd0, rts_n}, {7'd0, m_rts});
        chk(irq == (cfg_irq_full ? (mq.size() == D) : (mq.size() > 0)), "R10 irq",
            {7'd0, irq}, {7'd0, cfg_irq_full ? (mq.size() == D) : (mq.size() > 0)});
    endtask

    // one clock: drive at falling edge, model at rising edge, compare 1 ns later
    task automatic cyc(input logic w, input logic [7:0] d, input logic [2:0] f,
                       input logic s, input logic r, input logic e);
        @(negedge clk);
        wr_en = w; in_data = d; {in_brk, in_frm, in_par} = f;
        start_seen = s; rd_en = r; err_clr = e;
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic idle(); cyc(0, 8'h00, 3'b000, 0, 0, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(0, 8'h00, 3'b000, 0, 0, 0);
        cyc(0, 8'h00, 3'b000, 0, 0, 0);
        rst = 0;
        idle(); // reset state

        // R1 R2 R3 R4: fill, read out, read empty
        cyc(1, 8'hA1, 3'b001, 0, 0, 0);
        cyc(1, 8'hB2, 3'b010, 0, 0, 0);
        cyc(1, 8'hC3, 3'b000, 0, 0, 0);
        idle();
        cyc(0, 8'h00, 3'b000, 0, 1, 0);
        cyc(0, 8'h00, 3'b000, 0, 1, 0);
        cyc(0, 8'h00, 3'b000, 0, 1, 0);
        cyc(0, 8'h00, 3'b000, 0, 1, 0); // R3 empty read
        cyc(0, 8'h00, 3'b000, 0, 1, 0);

        // R6 R7: hold stage, overwrite, overrun, drain
        cyc(1, 8'h11, 3'b000, 0, 0, 0);
        cyc(1, 8'h22, 3'b000, 0, 0, 0);
        cyc(1, 8'h33, 3'b000, 0, 0, 0);
        cyc(1, 8'h44, 3'b000, 1, 0, 0);
        cyc(0, 8'h00, 3'b000, 1, 0, 0);
        cyc(1, 8'h55, 3'b000, 0, 0, 0);
        cyc(1, 8'h66, 3'b000, 1, 0, 0);
        idle();
        cyc(0, 8'h00, 3'b000, 0, 1, 0);
        repeat (4) cyc(0, 8'h00, 3'b000, 0, 1, 0);
        cyc(0, 8'h00, 3'b000, 0, 0, 1);

        // R11: read and write together on a full queue
        cyc(1, 8'h71, 3'b000, 0, 0, 0);
        cyc(1, 8'h72, 3'b000, 0, 0, 0);
        cyc(1, 8'h73, 3'b000, 0, 0, 0);
        cyc(1, 8'h74, 3'b001, 0, 1, 0);
        cyc(1, 8'h75, 3'b010, 1, 1, 0);
        repeat (4) cyc(0, 8'h00, 3'b000, 0, 1, 0);

        // R8: break character, sticky until clear; clear and set together
        cyc(1, 8'h00, 3'b100, 0, 0, 0);
        idle();
        cyc(1, 8'h00, 3'b100, 0, 1, 1);
        cyc(0, 8'h00, 3'b000, 0, 1, 1);
        idle();

        // R5: accumulated status
        cfg_accum = 1;
        cyc(1, 8'h01, 3'b001, 0, 0, 0);
        cyc(1, 8'h02, 3'b010, 0, 0, 0);
        cyc(1, 8'h03, 3'b000, 0, 0, 0);
        repeat (3) cyc(0, 8'h00, 3'b000, 0, 1, 0);
        idle();
        cyc(0, 8'h00, 3'b000, 0, 0, 1);
        idle();
        cfg_accum = 0;
        idle();

        // R9 R10: flow control and interrupt selection
        cfg_auto_rts = 1; cfg_irq_full = 1;
        cyc(1, 8'h81, 3'b000, 1, 0, 0);
        cyc(1, 8'h82, 3'b000, 0, 0, 0);
        cyc(1, 8'h83, 3'b000, 0, 0, 0);
        cyc(0, 8'h00, 3'b000, 1, 0, 0);
        idle();
        cyc(0, 8'h00, 3'b000, 0, 1, 0);
        idle();
        cfg_irq_full = 0;
        repeat (3) cyc(0, 8'h00, 3'b000, 0, 1, 0);
        cfg_auto_rts = 0;
        idle();

        // random traffic over all requirements
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                cfg_accum = 1'($urandom); cfg_auto_rts = 1'($urandom); cfg_irq_full = 1'($urandom);
            end
            cyc(1'($urandom_range(0, 2) != 0), 8'($urandom), 3'($urandom),
                1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0),
                1'($urandom_range(0, 15) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule